// File: doc/BRIEF.md
# Synchronous Flow-Through SRAM Bank Set

This block models a wide synchronous static RAM with per-lane write strobes. Each word is 72 bits wide and is split into eight lanes. Every lane is a data byte plus one parity bit. All control, address and write data inputs are captured on the rising clock. A cycle-start strobe decides whether a cycle takes a fresh address and chip select or continues on the address already held. Read data flows from the held address to the bus in the same cycle, with no output register. An asynchronous output enable per bank gates the bidirectional data bus.

Depth can be multiplied by placing several banks on one shared bus. Each bank has its own active-low select and output enable, and all banks share the address, strobes and data bus. The base organisation is 64K words (a 16-bit address). The address width is a parameter, and its default is kept small.

Top module: `ftsram_bank_set`

## Requirements
- R1: A word is LANES x 9 bits. Lane i occupies data_io[9i+8:9i], with its parity bit at 9i+8, and lane_wr_n[i] is the active-low write strobe of lane i.
- R2: At a rising edge with cyc_start_n low and bank_sel_n[b] low, bank b loads word_addr into its held address. The cycle is a write when any lane_wr_n bit is low and a read otherwise.
- R3: At a rising edge with cyc_start_n low and bank_sel_n[b] high, bank b becomes deselected and stops driving data_io.
- R4: After a read edge, the word at the held address is on data_io during the following cycle, before the next edge, whenever that bank's rd_oe_n is low.
- R5: rd_oe_n acts without a clock. Raising it releases the bus at once, and lowering it during a read cycle drives the bus at once.
- R6: A write updates only the lanes whose lane_wr_n bit is low. All other lanes of that word keep their previous contents.
- R7: During a write cycle the bank leaves data_io undriven, whatever the state of rd_oe_n.
- R8: At an edge with cyc_start_n high, a selected bank ignores bank_sel_n and word_addr. It reads or writes its held address, depending on lane_wr_n in that cycle.
- R9: A deselected bank stays deselected while cyc_start_n stays high. It performs no write and drives nothing until a strobe-low cycle selects it again.
- R10: A rising edge with rst_n low puts every bank in the deselected state with data_io undriven.
- R11: Banks hold separate contents at the same address, and at most one bank drives data_io at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all sampled inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start_n | input | 1 | Active-low cycle-start strobe; low takes a new address and select |
| bank_sel_n | input | BANKS | Active-low select, one per bank |
| rd_oe_n | input | BANKS | Asynchronous active-low output enable, one per bank |
| word_addr | input | ADDR_W | Word address, shared by all banks |
| lane_wr_n | input | LANES | Active-low per-lane write strobes |
| data_io | inout | LANES*9 | Shared bidirectional data bus |

## Verification
A write or a deselect takes effect at the edge that samples it. A read's data is due in the same cycle that follows that edge, with no extra pipeline delay. The bench applies each cycle's inputs at the falling clock edge and updates its reference memory at the rising edge. It releases its own bus drive one nanosecond later and samples data_io five nanoseconds after the rising edge, which lies inside the cycle where the result is due. The asynchronous output-enable checks toggle rd_oe_n and sample one nanosecond later inside the same cycle, so those checks do not depend on the clock.

// File: rtl/ftsram_pkg.sv
// Shared constants and types of the flow-through SRAM bank set.
// Assumes each lane is one data byte plus one parity bit.
package ftsram_pkg;
    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        BST_IDLE  = 2'd0,
        BST_READ  = 2'd1,
        BST_WRITE = 2'd2
    } bank_state_e;
endpackage

// File: rtl/ftsram_cycle_ctrl.sv
// Cycle decoder of one bank: decides deselect, read or write at each edge
// and keeps the held address. Assumes all inputs are stable around clk.
module ftsram_cycle_ctrl
    import ftsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start_n,
    input  logic              sel_n,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [LANES-1:0]  lane_wr_n,
    output logic [ADDR_W-1:0] held_addr,
    output logic              rd_active,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LANES-1:0]  wr_mask
);
    bank_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              any_wr;

    // Next cycle type and address from the strobe, select and lane strobes.
    always_comb begin
        any_wr  = ~&lane_wr_n;
        state_d = state_q;
        addr_d  = addr_q;
        if (!cyc_start_n) begin
            if (sel_n) begin
                state_d = BST_IDLE;
            end else begin
                addr_d  = word_addr;
                state_d = any_wr ? BST_WRITE : BST_READ;
            end
        end else if (state_q != BST_IDLE) begin
            state_d = any_wr ? BST_WRITE : BST_READ;
        end
    end

    // State and held address registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    assign held_addr = addr_q;
    assign rd_active = (state_q == BST_READ);
    assign wr_en     = rst_n && (state_d == BST_WRITE);
    assign wr_addr   = addr_d;
    assign wr_mask   = ~lane_wr_n;
endmodule

// File: rtl/ftsram_lane_array.sv
// Storage of one bank, split into one memory per lane so that each lane
// writes on its own. Reads are combinational from the held address.
module ftsram_lane_array
    import ftsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 8
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [LANES*LANE_W-1:0] wr_word,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Lane write: only when the lane strobe is active in a write cycle.
        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g]) begin
                mem[wr_addr] <= wr_word[g*LANE_W +: LANE_W];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] = mem[rd_addr];
    end
endmodule

// File: rtl/ftsram_bank.sv
// One bank: cycle decoder plus lane array, and the drive request for the
// shared bus. Assumes the enclosing level resolves the bus.
module ftsram_bank
    import ftsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cyc_start_n,
    input  logic                    sel_n,
    input  logic                    oe_n,
    input  logic [ADDR_W-1:0]       word_addr,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [LANES*LANE_W-1:0] wr_word,
    output logic [LANES*LANE_W-1:0] rd_word,
    output logic                    drive
);
    logic [ADDR_W-1:0] held_addr;
    logic              rd_active;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [LANES-1:0]  wr_mask;

    ftsram_cycle_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_start_n(cyc_start_n),
        .sel_n      (sel_n),
        .word_addr  (word_addr),
        .lane_wr_n  (lane_wr_n),
        .held_addr  (held_addr),
        .rd_active  (rd_active),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_mask    (wr_mask)
    );

    ftsram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_mask(wr_mask),
        .wr_word(wr_word),
        .rd_addr(held_addr),
        .rd_word(rd_word)
    );

    // The output enable gates the read path without a clock.
    assign drive = rd_active && !oe_n;
endmodule

// File: rtl/ftsram_bank_set.sv
// Set of BANKS synchronous flow-through SRAM banks on one shared data bus.
// Assumes the user selects at most one bank per strobe-low cycle.
module ftsram_bank_set
    import ftsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 8,
    parameter int BANKS  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cyc_start_n,
    input  logic [BANKS-1:0]        bank_sel_n,
    input  logic [BANKS-1:0]        rd_oe_n,
    input  logic [ADDR_W-1:0]       word_addr,
    input  logic [LANES-1:0]        lane_wr_n,
    inout  wire  [LANES*LANE_W-1:0] data_io
);
    localparam int WORD_W = LANES * LANE_W;

    logic [WORD_W-1:0] rd_words [BANKS];
    logic [BANKS-1:0]  bank_drv;
    logic [WORD_W-1:0] bus_word;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        ftsram_bank #(.ADDR_W(ADDR_W), .LANES(LANES)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .cyc_start_n(cyc_start_n),
            .sel_n      (bank_sel_n[b]),
            .oe_n       (rd_oe_n[b]),
            .word_addr  (word_addr),
            .lane_wr_n  (lane_wr_n),
            .wr_word    (data_io),
            .rd_word    (rd_words[b]),
            .drive      (bank_drv[b])
        );
    end

    // Merge the read word of whichever bank requests the bus.
    always_comb begin
        bus_word = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (bank_drv[b]) begin
                bus_word = bus_word | rd_words[b];
            end
        end
    end

    assign data_io = (|bank_drv) ? bus_word : {WORD_W{1'bz}};
endmodule

// File: rtl/ftsram_bank_set_chk.sv
// Protocol checker for the bank set, attached by bind below.
// Assumes bank_drv is the per-bank drive request inside the top.
module ftsram_bank_set_chk #(
    parameter int LANES = 8,
    parameter int BANKS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_start_n,
    input logic [BANKS-1:0] bank_sel_n,
    input logic [BANKS-1:0] rd_oe_n,
    input logic [LANES-1:0] lane_wr_n,
    input logic [BANKS-1:0] bank_drv
);
    p_single_driver_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_drv));

    for (genvar b = 0; b < BANKS; b++) begin : g_chk
        p_desel_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!cyc_start_n && bank_sel_n[b]) |=> !bank_drv[b]);

        p_write_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!cyc_start_n && !bank_sel_n[b] && !(&lane_wr_n)) |=> !bank_drv[b]);

        p_read_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!cyc_start_n && !bank_sel_n[b] && (&lane_wr_n)) |=> (rd_oe_n[b] || bank_drv[b]));

        p_stay_desel_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!cyc_start_n && bank_sel_n[b]) ##1 cyc_start_n |=> !bank_drv[b]);

        p_oe_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
            rd_oe_n[b] |-> !bank_drv[b]);
    end
endmodule

bind ftsram_bank_set ftsram_bank_set_chk #(.LANES(LANES), .BANKS(BANKS)) u_chk (.*);

// File: tb/tb_ftsram_bank_set.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural reference memory compared every cycle.
module tb_ftsram_bank_set;
    localparam int ADDR_W = 8;
    localparam int LANES  = 8;
    localparam int BANKS  = 2;
    localparam int WORD_W = LANES * 9;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cyc_start_n = 1'b1;
    logic [BANKS-1:0]  bank_sel_n = '1;
    logic [BANKS-1:0]  rd_oe_n = '1;
    logic [ADDR_W-1:0] word_addr = '0;
    logic [LANES-1:0]  lane_wr_n = '1;
    logic [WORD_W-1:0] tb_drv = '0;
    logic              tb_drv_en = 1'b0;
    wire  [WORD_W-1:0] data_io;

    assign data_io = tb_drv_en ? tb_drv : {WORD_W{1'bz}};

    ftsram_bank_set #(.ADDR_W(ADDR_W), .LANES(LANES), .BANKS(BANKS)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_start_n(cyc_start_n),
        .bank_sel_n (bank_sel_n),
        .rd_oe_n    (rd_oe_n),
        .word_addr  (word_addr),
        .lane_wr_n  (lane_wr_n),
        .data_io    (data_io)
    );

    always #10 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // Reference: per-bank state (0 idle, 1 read, 2 write), held address, memory.
    int                ref_st [BANKS];
    int                ref_adr [BANKS];
    logic [WORD_W-1:0] ref_mem [int];

    function automatic bit bus_idle(input logic [WORD_W-1:0] v);
        return (v === {WORD_W{1'bz}}) || (v === {WORD_W{1'b0}});
    endfunction

    function automatic logic [WORD_W-1:0] mk_data();
        logic [WORD_W-1:0] d;
        d = {$urandom(), $urandom(), $urandom()};
        for (int l = 0; l < LANES; l++) d[l*9+8] = 1'b1;
        return d;
    endfunction

    task automatic model_edge();
        for (int b = 0; b < BANKS; b++) begin
            if (!rst_n) begin
                ref_st[b] = 0;
            end else begin
                bit any_wr;
                any_wr = (lane_wr_n != '1);
                if (!cyc_start_n) begin
                    if (bank_sel_n[b]) ref_st[b] = 0;
                    else begin
                        ref_adr[b] = int'(word_addr);
                        ref_st[b] = any_wr ? 2 : 1;
                    end
                end else if (ref_st[b] != 0) begin
                    ref_st[b] = any_wr ? 2 : 1;
                end
                if (ref_st[b] == 2) begin
                    int k;
                    logic [WORD_W-1:0] w;
                    k = b * DEPTH + ref_adr[b];
                    w = ref_mem.exists(k) ? ref_mem[k] : '0;
                    for (int l = 0; l < LANES; l++)
                        if (!lane_wr_n[l]) w[l*9 +: 9] = tb_drv[l*9 +: 9];
                    ref_mem[k] = w;
                end
            end
        end
    endtask

    task automatic check(input string tag);
        logic [WORD_W-1:0] exp;
        bit idle;
        idle = 1'b1;
        exp = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (ref_st[b] == 1 && !rd_oe_n[b]) begin
                idle = 1'b0;
                exp = ref_mem[b * DEPTH + ref_adr[b]];
            end
        end
        vectors++;
        if (idle) begin
            if (!bus_idle(data_io)) begin
                miscompares++;
                $display("FAIL %s: data_io=%h expected=high-z", tag, data_io);
            end
        end else if (data_io !== exp) begin
            miscompares++;
            $display("FAIL %s: data_io=%h expected=%h", tag, data_io, exp);
        end
    endtask

    // One clock cycle: inputs at the falling edge, model at the rising edge.
    task automatic cyc(input logic a_n, input logic [1:0] c_n, input logic [7:0] ad,
                       input logic [7:0] w_n, input logic [WORD_W-1:0] wd,
                       input logic [1:0] o_n, input string tag);
        @(negedge clk);
        cyc_start_n = a_n;
        bank_sel_n  = c_n;
        word_addr   = ad;
        lane_wr_n   = w_n;
        rd_oe_n     = o_n;
        tb_drv      = wd;
        tb_drv_en   = (w_n != 8'hFF);
        @(posedge clk);
        model_edge();
        #1 tb_drv_en = 1'b0;
        #4 check(tag);
    endtask

    // Pulse one output enable low and back inside the current cycle.
    task automatic oe_pulse(input int b, input string tag);
        #1 rd_oe_n[b] = 1'b0;
        #1 check(tag);
        #1 rd_oe_n[b] = 1'b1;
        #1 check(tag);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog (all requirements): cycles=100000 expected=end of run");
            summary();
        end
    end

    initial begin
        logic [WORD_W-1:0] da, db, dc, dd, de, mix;
        for (int b = 0; b < BANKS; b++) begin
            ref_st[b] = 0;
            ref_adr[b] = 0;
        end

        // R10: reset state
        repeat (3) @(posedge clk);
        #5 check("R10");
        @(negedge clk) rst_n = 1'b1;
        cyc(1, 2'b11, 8'd0, 8'hFF, '0, 2'b00, "R10");

        // R2 R7: select bank 0 and write all lanes; the bus is idle in a write
        da = mk_data();
        cyc(0, 2'b10, 8'd5, 8'h00, da, 2'b00, "R7");
        // R8: continuation write ignores address and select
        db = mk_data();
        cyc(1, 2'b01, 8'd9, 8'h00, db, 2'b11, "R8");
        // R6 R1: lanes 0..3 only (lane_wr_n[i] low writes lane i)
        dc = mk_data();
        cyc(1, 2'b11, 8'd9, 8'hF0, dc, 2'b11, "R6");
        mix = {db[WORD_W-1:36], dc[35:0]};
        cyc(0, 2'b10, 8'd5, 8'hFF, '0, 2'b10, "R6");
        vectors++;
        if (data_io !== mix) begin
            miscompares++;
            $display("FAIL R6: data_io=%h expected=%h", data_io, mix);
        end
        // R5: held read with output enable high, then asynchronous pulse
        cyc(1, 2'b11, 8'd7, 8'hFF, '0, 2'b11, "R5");
        oe_pulse(0, "R5");

        // R11: same address in bank 1 holds separate data
        dd = mk_data();
        cyc(0, 2'b01, 8'd5, 8'h00, dd, 2'b11, "R11");
        cyc(0, 2'b01, 8'd5, 8'hFF, '0, 2'b00, "R11");
        cyc(0, 2'b10, 8'd5, 8'hFF, '0, 2'b00, "R11");

        // R3 R9: deselect, then strobe-high writes and reads do nothing
        cyc(0, 2'b11, 8'd5, 8'hFF, '0, 2'b00, "R3");
        de = mk_data();
        cyc(1, 2'b00, 8'd5, 8'h00, de, 2'b11, "R9");
        cyc(1, 2'b00, 8'd5, 8'hFF, '0, 2'b00, "R9");
        cyc(0, 2'b10, 8'd5, 8'hFF, '0, 2'b00, "R9");
        cyc(0, 2'b01, 8'd5, 8'hFF, '0, 2'b00, "R9");

        // R10: reset during an active read releases the bus
        @(negedge clk) rst_n = 1'b0;
        cyc(1, 2'b11, 8'd5, 8'hFF, '0, 2'b00, "R10");
        @(negedge clk) rst_n = 1'b1;

        // R2: fill addresses 0..15 of both banks
        for (int b = 0; b < BANKS; b++)
            for (int a = 0; a < 16; a++) begin
                logic [1:0] c;
                c = 2'b11;
                c[b] = 1'b0;
                cyc(0, c, 8'(a), 8'h00, mk_data(), 2'b11, "R2");
            end
        // R4: back-to-back reads, each word due in the cycle after its edge
        for (int a = 15; a >= 0; a--)
            cyc(0, 2'b10, 8'(a), 8'hFF, '0, 2'b00, "R4");

        // Random mix of all cycle kinds against the reference
        for (int i = 0; i < 600; i++) begin
            int r, b;
            logic [1:0] c;
            r = int'($urandom % 10);
            b = int'($urandom % BANKS);
            c = 2'b11;
            c[b] = 1'b0;
            case (r)
                0, 1: cyc(0, c, 8'($urandom % 16), 8'($urandom), mk_data() , 2'b11, "R2");
                2, 3: cyc(0, c, 8'($urandom % 16), 8'hFF, '0, 2'($urandom), "R4");
                4:    cyc(0, 2'b11, 8'($urandom), 8'hFF, '0, 2'($urandom), "R3");
                5, 6: cyc(1, 2'($urandom), 8'($urandom), 8'($urandom), mk_data(), 2'b11, "R8");
                default: cyc(1, 2'($urandom), 8'($urandom), 8'hFF, '0, 2'($urandom), "R8");
            endcase
        end

        done = 1'b1;
        summary();
    end
endmodule